// File: doc/BRIEF.md
# Registered ROM with Programmable Initialize

The block is a synchronous read-only memory of 8192 bytes, read through a pipeline output register. On every rising clock edge the byte at the presented 13-bit address is captured, and it stays on the output until the next rising edge. The address can therefore move on to the next location as soon as an edge has passed.

A programming write port fills the array before use. The same port also writes two configuration bytes that sit just above the array: a preload word and a role byte. The role byte gives the single control pin `ctl_i` one of three roles:

- an immediate (unclocked) active-low output enable;
- a clocked output enable, sampled on the clock edge;
- an immediate preload. Holding the pin low forces the preload word into the output and freezes clocked loading until the pin is released.

The three-state output is modelled as a data bus `data_o` plus a valid-drive flag `oe_o`.

Top module: `regrom_top`

## Requirements
- R1: On each rising clock edge the array byte at `addr_i` is captured, and `data_o` shows it from that edge until the next edge. This holds whether the outputs are enabled or not.
- R2: Changing `addr_i` between two edges leaves `data_o` unchanged until the next edge.
- R3: With `prog_we_i` high at an edge, `prog_data_i` is stored as follows:
  - `prog_addr_i` 0x0000–0x1FFF writes that array location;
  - 0x2000 writes the preload word;
  - 0x2001 writes the role byte.
- R4: Role byte values:
  - 0x00 selects the immediate enable;
  - 0x01 selects the clocked enable;
  - 0x02 selects the preload role;
  - any other value acts as 0x00.
- R5: In the immediate enable role, `oe_o` equals the inverse of `ctl_i` at all times, with no clock edge needed.
- R6: In the clocked enable role, `oe_o` changes only at a rising edge, taking the inverse of `ctl_i` sampled there. A synchronous reset sets it to 1.
- R7: In the preload role, `oe_o` is always 1. Driving `ctl_i` low puts the preload word on `data_o` at once, without a clock edge.
- R8: In the preload role, clock edges while `ctl_i` is low leave `data_o` at the preload word. `data_o` keeps the preload word after release, and the first edge with `ctl_i` high loads the addressed array byte.
- R9: A synchronous reset clears the output register to 0x00. An unprogrammed preload word is 0x00, so the preload then clears the output; programming it to 0xFF makes it a preset to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 13 | Read address |
| ctl_i | input | 1 | Shared control pin; its role is set by the role byte |
| prog_we_i | input | 1 | Programming write strobe |
| prog_addr_i | input | 14 | Programming address (array, preload word, role byte) |
| prog_data_i | input | 8 | Programming data |
| data_o | output | 8 | Registered read data |
| oe_o | output | 1 | Output drive enable (0 = high impedance) |

## Verification
On every clock edge, the embedded properties check three things:
- the output enable matches the active role: inverse pin in the immediate role, the previous edge's sampled pin in the clocked role, and always on in the preload role;
- a held-low preload pin shows the preload word;
- the read register is zero just after reset.

Some behaviour falls between clock edges or needs known memory contents, so only the directed scenarios can show it:
- the preload appearing without a clock;
- the preload word persisting after release until the next edge;
- address changes mid-cycle being ignored;
- the correct array byte arriving one edge after an address is presented;
- out-of-range role bytes falling back to the immediate enable.

// File: rtl/regrom_pkg.sv
package regrom_pkg;
  typedef enum logic [1:0] {
    ROLE_EN_ASYNC = 2'd0,
    ROLE_EN_SYNC  = 2'd1,
    ROLE_PRELOAD  = 2'd2
  } role_e;

  localparam logic [7:0] ROLE_CODE_SYNC    = 8'h01;
  localparam logic [7:0] ROLE_CODE_PRELOAD = 8'h02;
endpackage

// File: rtl/regrom_array.sv
module regrom_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port used only while programming
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= mem[rd_addr];
  end

  // R9: read register is cleared by reset
  p_read_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_q == '0))
    else $error("read register not cleared by reset");
endmodule

// File: rtl/regrom_cfg.sv
module regrom_cfg
  import regrom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              prog_we,
  input  logic [ADDR_W:0]   prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] preload_word,
  output role_e             role
);
  localparam int PA_W = ADDR_W + 1;
  localparam logic [PA_W-1:0] PRELOAD_LOC = PA_W'(1 << ADDR_W);
  localparam logic [PA_W-1:0] ROLE_LOC    = PA_W'((1 << ADDR_W) + 1);

  // Nonvolatile configuration: power-up value is the unprogrammed state
  logic [DATA_W-1:0] preload_q = '0;
  logic [7:0]        role_q    = '0;

  always_ff @(posedge clk) begin
    if (prog_we && prog_addr == PRELOAD_LOC) preload_q <= prog_data;
    if (prog_we && prog_addr == ROLE_LOC)    role_q    <= 8'(prog_data);
  end

  // Unknown codes fall back to the immediate enable role
  always_comb begin
    unique case (role_q)
      ROLE_CODE_SYNC:    role = ROLE_EN_SYNC;
      ROLE_CODE_PRELOAD: role = ROLE_PRELOAD;
      default:           role = ROLE_EN_ASYNC;
    endcase
  end

  assign preload_word = preload_q;
endmodule

// File: rtl/regrom_ostage.sv
module regrom_ostage
  import regrom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  role_e             role,
  input  logic              ctl,
  input  logic [DATA_W-1:0] preload_word,
  input  logic [DATA_W-1:0] rd_q,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  logic preload_act;
  logic preload_hold;
  logic sync_oe;

  assign preload_act = (role == ROLE_PRELOAD) && !ctl;

  // Set immediately by the pin, cleared by the first edge after release
  always_ff @(posedge clk or posedge preload_act) begin
    if (preload_act) preload_hold <= 1'b1;
    else             preload_hold <= 1'b0;
  end

  // Clocked enable, starts enabled after reset
  always_ff @(posedge clk) begin
    if (rst) sync_oe <= 1'b1;
    else     sync_oe <= !ctl;
  end

  assign data_o = preload_hold ? preload_word : rd_q;

  always_comb begin
    unique case (role)
      ROLE_EN_SYNC: oe_o = sync_oe;
      ROLE_PRELOAD: oe_o = 1'b1;
      default:      oe_o = !ctl;
    endcase
  end

  p_preload_shows_r7: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_PRELOAD && !ctl) |-> (data_o == preload_word))
    else $error("preload word not on output");

  p_preload_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_PRELOAD) |-> oe_o)
    else $error("output disabled in preload role");

  p_async_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_EN_ASYNC) |-> (oe_o == !ctl))
    else $error("immediate enable mismatch");

  p_sync_oe_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && role == ROLE_EN_SYNC && $past(role) == ROLE_EN_SYNC)
      |-> (oe_o == !$past(ctl)))
    else $error("clocked enable mismatch");
endmodule

// File: rtl/regrom_top.sv
module regrom_top
  import regrom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctl_i,
  input  logic              prog_we_i,
  input  logic [ADDR_W:0]   prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] preload_word;
  role_e             role;
  logic              arr_we;

  // Top address bit set selects the configuration bytes
  assign arr_we = prog_we_i && !prog_addr_i[ADDR_W];

  regrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (addr_i),
    .wr_en   (arr_we),
    .wr_addr (prog_addr_i[ADDR_W-1:0]),
    .wr_data (prog_data_i),
    .rd_q    (rd_q)
  );

  regrom_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk          (clk),
    .prog_we      (prog_we_i),
    .prog_addr    (prog_addr_i),
    .prog_data    (prog_data_i),
    .preload_word (preload_word),
    .role         (role)
  );

  regrom_ostage #(.DATA_W(DATA_W)) u_ostage (
    .clk          (clk),
    .rst          (rst),
    .role         (role),
    .ctl          (ctl_i),
    .preload_word (preload_word),
    .rd_q         (rd_q),
    .data_o       (data_o),
    .oe_o         (oe_o)
  );
endmodule

// File: tb/sim_regrom_top.sv
`timescale 1ns/1ps
module sim_regrom_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr_i = '0;
  logic        ctl_i = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [13:0] prog_addr_i = '0;
  logic [7:0]  prog_data_i = '0;
  logic [7:0]  data_o;
  logic        oe_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  regrom_top u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .ctl_i(ctl_i),
    .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
    .data_o(data_o), .oe_o(oe_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) ^ (a >> 6));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prog(int a, logic [7:0] d);
    @(negedge clk);
    prog_we_i = 1'b1; prog_addr_i = 14'(a); prog_data_i = d;
    @(negedge clk);
    prog_we_i = 1'b0;
  endtask

  task automatic read_at(int a);
    @(negedge clk); addr_i = 13'(a);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset clears data", data_o, 8'h00);
    chk("R9 reset oe", {7'b0, oe_o}, 8'h01);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_fill;
    for (int a = 0; a < 8192; a++) begin
      @(negedge clk);
      prog_we_i = 1'b1; prog_addr_i = 14'(a); prog_data_i = pat(a);
    end
    @(negedge clk); prog_we_i = 1'b0;
  endtask

  task automatic t_read;
    int lst [5] = '{0, 1, 'h1FFF, 'h1234, 'h0AAA};
    foreach (lst[i]) begin
      read_at(lst[i]);
      chk("R1 R3 read", data_o, pat(lst[i]));
    end
  endtask

  task automatic t_hold;
    read_at('h100);
    chk("R1 read 0x100", data_o, pat('h100));
    addr_i = 13'h200;
    #1 chk("R2 hold mid-cycle", data_o, pat('h100));
    @(posedge clk); #1;
    chk("R2 new address after edge", data_o, pat('h200));
  endtask

  task automatic t_async(string tag);
    @(negedge clk); ctl_i = 1'b1;
    #0.5 chk({tag, " immediate disable"}, {7'b0, oe_o}, 8'h00);
    ctl_i = 1'b0;
    #0.5 chk({tag, " immediate enable"}, {7'b0, oe_o}, 8'h01);
  endtask

  task automatic t_sync;
    prog('h2001, 8'h01);
    @(negedge clk); ctl_i = 1'b1;
    #0.5 chk("R6 no change before edge", {7'b0, oe_o}, 8'h01);
    @(posedge clk); #1;
    chk("R6 disabled at edge", {7'b0, oe_o}, 8'h00);
    read_at('h0077);
    chk("R1 read while disabled", data_o, pat('h0077));
    @(negedge clk); ctl_i = 1'b0;
    #0.5 chk("R6 still off before edge", {7'b0, oe_o}, 8'h00);
    @(posedge clk); #1;
    chk("R4 R6 enabled at edge", {7'b0, oe_o}, 8'h01);
    @(negedge clk); ctl_i = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); ctl_i = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    chk("R6 reset enables", {7'b0, oe_o}, 8'h01);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_preload_clear;
    @(negedge clk); ctl_i = 1'b1;
    prog('h2001, 8'h02);
    read_at('h0033);
    chk("R1 read 0x33", data_o, pat('h0033));
    ctl_i = 1'b0;
    #0.5 chk("R9 unprogrammed preload clears", data_o, 8'h00);
    chk("R7 oe forced on", {7'b0, oe_o}, 8'h01);
    ctl_i = 1'b1;
    #0.5 chk("R8 cleared value held after release", data_o, 8'h00);
    @(posedge clk); #1;
    chk("R8 first edge loads array", data_o, pat('h0033));
  endtask

  task automatic t_preload_hold;
    prog('h2000, 8'hA5);
    @(negedge clk); ctl_i = 1'b0;
    #0.5 chk("R7 immediate preload", data_o, 8'hA5);
    for (int k = 1; k <= 3; k++) begin
      read_at(k * 100);
      chk("R8 edge ignored while low", data_o, 8'hA5);
      chk("R7 oe on", {7'b0, oe_o}, 8'h01);
    end
    @(negedge clk); ctl_i = 1'b1; addr_i = 13'h1ABC;
    #0.5 chk("R8 preload held after release", data_o, 8'hA5);
    @(posedge clk); #1;
    chk("R8 array after release", data_o, pat('h1ABC));
  endtask

  task automatic t_preset;
    prog('h2000, 8'hFF);
    @(negedge clk); ctl_i = 1'b0;
    #0.5 chk("R9 preset to ones", data_o, 8'hFF);
    @(negedge clk); ctl_i = 1'b1;
    @(posedge clk); #1;
    chk("R8 array after preset", data_o, pat('h1ABC));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_read();
    t_hold();
    t_async("R5");
    prog('h2001, 8'h07);
    t_async("R4 unknown code");
    t_sync();
    t_preload_clear();
    t_preload_hold();
    t_preset();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule